// File: doc/BRIEF.md
# I2C Mailbox Register Master

This block lets a host perform single-byte register writes and register reads on an I2C target through four 16-bit memory-mapped words. The host first loads a register index, plus a data byte for a write, into an outbound mailbox word. It then posts one command word that names the 7-bit target address and the direction. That single command makes the block run the complete bus transaction and drive SCL and SDA as open-drain pull-down enables.

A write transaction sends START, the address with the write bit, the index, the data byte and STOP. A read transaction sends START, the address with the write bit, the index, a repeated START, the address with the read bit, receives one byte, answers it with NACK and sends STOP. The host polls a busy flag and collects the result from an inbound mailbox word. Completion of a read and a missing acknowledge are each reported in their own sticky flag, and the host clears either one by writing 1 to it. Each bit on the bus takes four phases of `PHASE_DIV` system cycles.

Top module: `i2c_mailbox_master`

## Requirements
- R1: Word address 0 is the outbound mailbox. Bits 7:0 hold the target register index and bits 15:8 hold the byte that a write transaction sends after the index.
- R2: A write to word address 1 starts a transaction only when bits 15:14 are 11. Bits 7:1 carry the 7-bit target address. Bit 10 = 1 selects a register write (0xC400 form) and bit 10 = 0 selects a register read (0xC000 form). Any other value in bits 15:14 starts nothing.
- R3: Status word address 2, bit 12, reads 1 from the cycle after an accepted command until the transaction has finished, and reads 0 at all other times.
- R4: A command posted while bit 12 is 1 is ignored. It produces no bus activity and does not change the transaction in flight.
- R5: Status bit 14 is set when a read transaction completes with every byte acknowledged, and writing 1 to bit 14 clears it. If the set and the clear fall in the same cycle, the set wins.
- R6: Word address 3, bits 15:8, hold the byte received by the last successful read. Bits 7:0 read 0.
- R7: A missing acknowledge after any byte the block sends ends the transaction with STOP, clears bit 12 and sets status bit 13. Bit 13 stays set until 1 is written to it.
- R8: A read transaction issues exactly two START conditions (the second being the repeated START with the read bit) and one STOP, and answers the received byte with NACK. A write transaction issues one START and one STOP.
- R9: SDA changes while SCL is released only to form a START or a STOP condition.
- R10: Successive rising edges of SCL within a transaction are 4 × `PHASE_DIV` system cycles apart. The block waits in the high phase while SCL is held low externally.
- R11: After reset all status bits, both pull-down enables and the inbound mailbox are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address (0 outbound, 1 command, 2 status, 3 inbound) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The completion of a read and a host write of 1 to the read-done bit can land in the same clock edge. The bench provokes this by timing a clear write to the exact edge at which a read's completion reaches the status register. That edge is computed from the fixed length of a read, 156 phases of `PHASE_DIV` cycles after the accepting edge. The bench expects the flag to survive there and to be cleared by the same write issued one edge later. A second overlap is a command posted while a transaction is running. The bench judges that case by counting START conditions and by checking the target's register contents afterwards.

// File: rtl/i2cmb_pkg.sv
// Shared word map, status bit positions and bus symbol encoding for the
// mailbox I2C master. Assumes a 2-bit word address space.
package i2cmb_pkg;
    localparam logic [1:0] WA_OUTBOX = 2'd0;
    localparam logic [1:0] WA_CMD    = 2'd1;
    localparam logic [1:0] WA_STATUS = 2'd2;
    localparam logic [1:0] WA_INBOX  = 2'd3;

    localparam int SB_BUSY  = 12;
    localparam int SB_NACK  = 13;
    localparam int SB_RDONE = 14;
    localparam int CB_WRITE = 10;

    typedef enum logic [2:0] {
        SYM_IDLE,
        SYM_START,
        SYM_WBYTE,
        SYM_RBYTE,
        SYM_STOP
    } sym_e;
endpackage

// File: rtl/i2cmb_phase_timer.sv
// Phase timer: pulses tick once every DIV cycles while run is high.
// Assumes DIV >= 2. Restarts from zero whenever run is low, so the first
// phase of a transaction is a full DIV cycles long.
module i2cmb_phase_timer #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count system cycles within a phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    // Ticks are never adjacent: each phase lasts at least two cycles.
    assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/i2cmb_engine.sv
// Bus engine: runs one complete register write or register read on I2C.
// Each bit takes four phases: SCL low (SDA set up), SCL rising, SCL high
// (SDA sampled, waiting while SCL is held low externally), SCL low.
// Assumes start_i arrives only while busy_o is low.
module i2cmb_engine
    import i2cmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rd_i,
    input  logic [6:0] slave_i,
    input  logic [7:0] idx_i,
    input  logic [7:0] wdat_i,
    input  logic       tick_i,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       run_o,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       busy_o,
    output logic       done_o,
    output logic       nack_o,
    output logic       is_rd_o,
    output logic [7:0] rbyte_o
);
    sym_e       st;
    logic [1:0] phase;
    logic [3:0] bitc;
    logic [1:0] bidx;
    logic [7:0] shreg;
    logic       ack_bad, is_rd, nack_q, done_q;
    logic [6:0] sla;
    logic [7:0] idx_q, wd_q;
    logic       adv, scl_n, sda_n;

    // Advance a phase on each tick, but hold the high phase while SCL is low.
    assign adv = tick_i && !(phase == 2'd2 && !scl_in);

    // Symbol sequencer: START, bytes, optional repeated START, STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SYM_IDLE; phase <= '0; bitc <= '0; bidx <= '0;
            shreg <= '0; ack_bad <= 1'b0; is_rd <= 1'b0; nack_q <= 1'b0;
            done_q <= 1'b0; sla <= '0; idx_q <= '0; wd_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (st == SYM_IDLE) begin
                if (start_i) begin
                    st <= SYM_START; phase <= '0; bidx <= '0;
                    is_rd <= rd_i; sla <= slave_i; idx_q <= idx_i;
                    wd_q <= wdat_i; nack_q <= 1'b0; ack_bad <= 1'b0;
                end
            end else if (adv) begin
                phase <= phase + 2'd1;
                if (phase == 2'd2) begin
                    if (st == SYM_WBYTE && bitc == 4'd8) ack_bad <= sda_in;
                    if (st == SYM_RBYTE && bitc < 4'd8) shreg <= {shreg[6:0], sda_in};
                end else if (phase == 2'd3) begin
                    case (st)
                        SYM_START: begin
                            st <= SYM_WBYTE; bitc <= '0;
                            shreg <= {sla, (bidx != 2'd0)};
                        end
                        SYM_WBYTE: begin
                            if (bitc < 4'd8) begin
                                shreg <= {shreg[6:0], 1'b0};
                                bitc <= bitc + 4'd1;
                            end else if (ack_bad) begin
                                st <= SYM_STOP; nack_q <= 1'b1;
                            end else begin
                                bitc <= '0;
                                case (bidx)
                                    2'd0: begin shreg <= idx_q; bidx <= 2'd1; end
                                    2'd1: begin
                                        bidx <= 2'd2;
                                        if (is_rd) st <= SYM_START;
                                        else shreg <= wd_q;
                                    end
                                    default: st <= is_rd ? SYM_RBYTE : SYM_STOP;
                                endcase
                            end
                        end
                        SYM_RBYTE: begin
                            if (bitc < 4'd8) bitc <= bitc + 4'd1;
                            else st <= SYM_STOP;
                        end
                        SYM_STOP: begin st <= SYM_IDLE; done_q <= 1'b1; end
                        default: st <= SYM_IDLE;
                    endcase
                end
            end
        end
    end

    // Line levels wanted for the current symbol and phase.
    always_comb begin
        scl_n = 1'b0;
        sda_n = 1'b0;
        case (st)
            SYM_START: begin scl_n = (phase == 2'd0) || (phase == 2'd3); sda_n = phase[1]; end
            SYM_WBYTE: begin
                scl_n = (phase == 2'd0) || (phase == 2'd3);
                sda_n = (bitc < 4'd8) && !shreg[7];
            end
            SYM_RBYTE: scl_n = (phase == 2'd0) || (phase == 2'd3);
            SYM_STOP:  begin scl_n = (phase == 2'd0); sda_n = !phase[1]; end
            default: ;
        endcase
    end

    // Register the pull-down enables so the pins never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin scl_pull <= 1'b0; sda_pull <= 1'b0; end
        else begin scl_pull <= scl_n; sda_pull <= sda_n; end
    end

    assign run_o   = (st != SYM_IDLE);
    assign busy_o  = (st != SYM_IDLE) || done_q;
    assign done_o  = done_q;
    assign nack_o  = nack_q;
    assign is_rd_o = is_rd;
    assign rbyte_o = shreg;

    // SDA moves under a released SCL only inside START or STOP symbols.
    assert_sda_stable_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull)))
        |-> ($past(st) == SYM_START || $past(st) == SYM_STOP));
    // A command arriving mid-transaction leaves the latched direction alone.
    assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SYM_IDLE && start_i) |=> $stable(is_rd));
    // A detected missing acknowledge always leads into STOP.
    assert_nack_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_q) |-> (st == SYM_STOP));
    // Completion is reported only once the bus sequencer is idle.
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (st == SYM_IDLE));
endmodule

// File: rtl/i2cmb_regs.sv
// Register file and command decode: outbound/inbound mailboxes, command
// word and status flags. Assumes a single-cycle write strobe; reads are
// combinational from the word address.
module i2cmb_regs
    import i2cmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        busy_i,
    input  logic        done_i,
    input  logic        nack_i,
    input  logic        rd_i,
    input  logic [7:0]  rbyte_i,
    output logic        start_o,
    output logic        start_rd_o,
    output logic [6:0]  slave_o,
    output logic [7:0]  idx_o,
    output logic [7:0]  wdat_o
);
    logic [15:0] outbox;
    logic [7:0]  inbox;
    logic        rdone, nerr;
    logic        wr_stat;

    assign wr_stat = bus_wr && (bus_addr == WA_STATUS);

    // Command decode: start only on the 11 tag and only when idle.
    assign start_o    = bus_wr && (bus_addr == WA_CMD) && (bus_wdata[15:14] == 2'b11) && !busy_i;
    assign start_rd_o = !bus_wdata[CB_WRITE];
    assign slave_o    = bus_wdata[7:1];
    assign idx_o      = outbox[7:0];
    assign wdat_o     = outbox[15:8];

    // Outbound mailbox write.
    always_ff @(posedge clk) begin
        if (!rst_n) outbox <= '0;
        else if (bus_wr && bus_addr == WA_OUTBOX) outbox <= bus_wdata;
    end

    // Completion flags: set on engine result, cleared by writing 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdone <= 1'b0; nerr <= 1'b0; inbox <= '0;
        end else begin
            if (done_i && nack_i) nerr <= 1'b1;
            else if (wr_stat && bus_wdata[SB_NACK]) nerr <= 1'b0;
            if (done_i && rd_i && !nack_i) begin
                rdone <= 1'b1; inbox <= rbyte_i;
            end else if (wr_stat && bus_wdata[SB_RDONE]) rdone <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            WA_OUTBOX: bus_rdata = outbox;
            WA_STATUS: bus_rdata = {1'b0, rdone, nerr, busy_i, 12'h000};
            WA_INBOX:  bus_rdata = {inbox, 8'h00};
            default:   bus_rdata = 16'h0000;
        endcase
    end

    // A successful read completion is visible the next cycle even under a clear.
    assert_rdone_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rd_i && !nack_i) |=> rdone);
    // The error flag only drops on an explicit clear.
    assert_nerr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nerr && !(wr_stat && bus_wdata[SB_NACK])) |=> nerr);
    // Inbound data changes only with a successful read completion.
    assert_inbox_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_i && rd_i && !nack_i) |=> $stable(inbox));
endmodule

// File: rtl/i2c_mailbox_master.sv
// Top level: mailbox register front end driving a single-byte register
// write/read I2C engine. Open-drain pins are exposed as pull-down enables
// plus sensed levels; the pads and pull-ups are outside this block.
module i2c_mailbox_master #(
    parameter int PHASE_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        scl_in,
    output logic        scl_pull,
    input  logic        sda_in,
    output logic        sda_pull
);
    logic       start, start_rd, tick, run, busy, done, nack, is_rd;
    logic [6:0] slave;
    logic [7:0] idx, wdat, rbyte;

    i2cmb_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy),
        .done_i(done), .nack_i(nack), .rd_i(is_rd), .rbyte_i(rbyte),
        .start_o(start), .start_rd_o(start_rd), .slave_o(slave),
        .idx_o(idx), .wdat_o(wdat)
    );

    i2cmb_phase_timer #(.DIV(PHASE_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    i2cmb_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(start_rd),
        .slave_i(slave), .idx_i(idx), .wdat_i(wdat), .tick_i(tick),
        .scl_in(scl_in), .sda_in(sda_in), .run_o(run), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .busy_o(busy), .done_o(done), .nack_o(nack),
        .is_rd_o(is_rd), .rbyte_o(rbyte)
    );
endmodule

// File: tb/i2c_mailbox_master_tb.sv
module i2c_mailbox_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam logic [6:0] SLV = 7'h2B;
    localparam logic [6:0] BAD = 7'h31;
    localparam int RD_PHASES = 156;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic scl_pull, sda_pull;
    logic s_drv;
    wire scl_line = !scl_pull;
    wire sda_line = !sda_pull && !s_drv;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mailbox_master #(.PHASE_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_line),
        .scl_pull(scl_pull), .sda_in(sda_line), .sda_pull(sda_pull)
    );

    // ---------------- target model (sampled at system clock) --------------
    logic [7:0] mem [256];
    logic scl_q, sda_q, s_act, s_inack, s_tx, s_addrd, had_rise;
    logic [7:0] s_sh, s_ptr, s_txb;
    int s_bitc, s_bytec, cyc, last_rise;
    int n_start, n_stop, n_mnack, n_perbad;

    function automatic logic [7:0] init_val(int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = init_val(i);
            scl_q = 1'b1; sda_q = 1'b1; s_act = 0; s_inack = 0; s_tx = 0;
            s_addrd = 0; had_rise = 0; s_sh = 0; s_ptr = 0; s_txb = 0;
            s_bitc = 0; s_bytec = 0; cyc = 0; last_rise = 0;
            n_start = 0; n_stop = 0; n_mnack = 0; n_perbad = 0;
            s_drv <= 1'b0;
        end else begin
            cyc++;
            if (scl_line && scl_q && sda_q && !sda_line) begin
                n_start++; s_act = 1; s_bitc = 0; s_bytec = 0; s_inack = 0;
                s_tx = 0; s_drv <= 1'b0;
            end else if (scl_line && scl_q && !sda_q && sda_line) begin
                n_stop++; s_act = 0; had_rise = 0; s_drv <= 1'b0;
            end else if (scl_line && !scl_q) begin
                if (had_rise && (cyc - last_rise) != 4*DIV) n_perbad++;
                had_rise = 1; last_rise = cyc;
                if (s_act) begin
                    if (!s_inack && s_bitc < 8) begin
                        s_sh = {s_sh[6:0], sda_line}; s_bitc++;
                    end else if (s_inack && s_tx && sda_line) n_mnack++;
                end
            end else if (s_act && !scl_line && scl_q) begin
                if (s_inack) begin
                    s_inack = 0; s_bitc = 0;
                    if (s_tx && s_bytec == 0) s_drv <= !s_txb[7];
                    else s_drv <= 1'b0;
                    s_bytec++;
                end else if (s_bitc == 8) begin
                    s_inack = 1;
                    if (s_tx) s_drv <= 1'b0;
                    else if (s_bytec == 0) begin
                        if (s_sh[7:1] == SLV) begin
                            s_addrd = 1; s_tx = s_sh[0]; s_txb = mem[s_ptr]; s_drv <= 1'b1;
                        end else begin s_addrd = 0; s_drv <= 1'b0; end
                    end else if (!s_addrd) s_drv <= 1'b0;
                    else if (s_bytec == 1) begin s_ptr = s_sh; s_drv <= 1'b1; end
                    else if (s_ptr == 8'hFF) s_drv <= 1'b0;
                    else begin mem[s_ptr] = s_sh; s_drv <= 1'b1; end
                end else if (s_tx && s_bitc < 8) s_drv <= !s_txb[3'(7 - s_bitc)];
            end
            scl_q = scl_line; sda_q = sda_line;
        end
    end

    // ---------------- bench helpers ----------------
    logic [7:0] exp_mem [256];
    logic [7:0] exp_inbox;

    function automatic logic [15:0] cmd_word(logic [6:0] a, logic rd);
        return 16'hC000 | (rd ? 16'h0000 : 16'h0400) | {8'h00, a, 1'b0};
    endfunction

    function automatic logic [15:0] exp_status(logic busy, logic err, logic rdone);
        return {1'b0, rdone, err, busy, 12'h000};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [15:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 5000; i++) begin
            bus_read(2'd2, s);
            if (!s[12]) return;
            @(negedge clk);
        end
        chk("R3 busy timeout", 1, 0);
    endtask

    // One full transaction with expected results computed from the requirements.
    task automatic txn(logic rd, logic [7:0] idx, logic [7:0] dat, logic [6:0] a);
        int st0, sp0, mn0, pb0;
        logic [15:0] s, ib;
        logic ok;
        bus_write(2'd0, {dat, idx});
        st0 = n_start; sp0 = n_stop; mn0 = n_mnack; pb0 = n_perbad;
        bus_write(2'd1, cmd_word(a, rd));
        wait_idle();
        ok = (a == SLV) && (rd || idx != 8'hFF);
        if (!rd && ok) exp_mem[idx] = dat;
        if (rd && ok) exp_inbox = exp_mem[idx];
        bus_read(2'd2, s);
        chk("R7 status after txn", s, exp_status(0, !ok, rd && ok));
        bus_read(2'd3, ib);
        chk("R6 inbound mailbox", ib, {exp_inbox, 8'h00});
        chk("R1 target register", mem[idx], exp_mem[idx]);
        chk("R8 start count", n_start - st0, (rd && a == SLV) ? 2 : 1);
        chk("R8 stop count", n_stop - sp0, 1);
        chk("R8 master nack", n_mnack - mn0, (rd && ok) ? 1 : 0);
        chk("R10 scl period", n_perbad - pb0, 0);
        bus_write(2'd2, 16'h6000);
        bus_read(2'd2, s);
        chk("R5 flags cleared", s, 16'h0000);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] s, ib;
        int st0;
        void'($urandom(32'h1D2C3B4A));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        exp_inbox = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        bus_read(2'd2, s);
        chk("R11 status after reset", s, 16'h0000);
        bus_read(2'd3, ib);
        chk("R11 inbox after reset", ib, 16'h0000);
        chk("R11 pulls after reset", {scl_pull, sda_pull}, 2'b00);

        // R1 directed write, R6 directed read back
        txn(1'b0, 8'h10, 8'hA7, SLV);
        txn(1'b1, 8'h10, 8'h00, SLV);
        txn(1'b1, 8'h00, 8'h00, SLV);

        // R3 busy visible the cycle after the command; R4 second command ignored
        bus_write(2'd0, 16'h1120);
        st0 = n_start;
        bus_write(2'd1, cmd_word(SLV, 1'b0));
        bus_read(2'd2, s);
        chk("R3 busy after command", s[12], 1'b1);
        bus_write(2'd0, 16'h2221);
        bus_write(2'd1, cmd_word(SLV, 1'b0));
        wait_idle();
        exp_mem[8'h20] = 8'h11;
        chk("R4 first write landed", mem[8'h20], 8'h11);
        chk("R4 ignored command", mem[8'h21], exp_mem[8'h21]);
        chk("R4 single start", n_start - st0, 1);

        // R2 command without the 11 tag starts nothing
        st0 = n_start;
        bus_write(2'd1, 16'h8400 | {8'h00, SLV, 1'b0});
        bus_read(2'd2, s);
        chk("R2 untagged not busy", s[12], 1'b0);
        repeat (40) @(negedge clk);
        chk("R2 untagged no start", n_start - st0, 0);

        // R7 address NACK, error sticky until cleared
        bus_write(2'd0, 16'h3344);
        bus_write(2'd1, cmd_word(BAD, 1'b1));
        wait_idle();
        bus_read(2'd2, s);
        chk("R7 error on address nack", s, exp_status(0, 1, 0));
        repeat (20) @(negedge clk);
        bus_write(2'd2, 16'h4000);
        bus_read(2'd2, s);
        chk("R7 error sticky", s[13], 1'b1);
        bus_write(2'd2, 16'h2000);
        bus_read(2'd2, s);
        chk("R7 error cleared", s[13], 1'b0);

        // R7 data-stage NACK
        txn(1'b0, 8'hFF, 8'h55, SLV);

        // R5 clear coinciding with completion: set wins
        bus_write(2'd0, 16'h0010);
        bus_write(2'd1, cmd_word(SLV, 1'b1));
        repeat (RD_PHASES*DIV) @(negedge clk);
        bus_write(2'd2, 16'h4000);
        bus_read(2'd2, s);
        chk("R5 set wins over clear", s, exp_status(0, 0, 1));
        // R5 clear one edge after completion clears
        bus_write(2'd2, 16'h4000);
        bus_write(2'd1, cmd_word(SLV, 1'b1));
        repeat (RD_PHASES*DIV + 1) @(negedge clk);
        bus_write(2'd2, 16'h4000);
        bus_read(2'd2, s);
        chk("R5 clear after set", s, exp_status(0, 0, 0));
        bus_read(2'd3, ib);
        chk("R6 data after collision", ib, {exp_mem[8'h10], 8'h00});
        exp_inbox = exp_mem[8'h10];

        // Random transactions
        for (int k = 0; k < 25; k++) begin
            logic rd;
            logic [7:0] idx, dat;
            logic [6:0] a;
            rd  = 1'($urandom % 2);
            idx = 8'($urandom % 256);
            dat = 8'($urandom);
            a   = (($urandom % 6) == 0) ? BAD : SLV;
            txn(rd, idx, dat, a);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule